// File: doc/BRIEF.md
# Panel Power Sequencer

This block brings a display panel out of deep standby and later puts it back to sleep. It does this by handing a fixed series of register writes, one at a time, to a separate serial command writer. Each write is a command code with zero, one or two payload bytes. Power-up begins with three null wake-up commands, each followed by a timed pause of about a millisecond and a half. Next come the power and mode settings, a sleep-exit command, a long list of panel tuning writes and a final display-on command. Power-down is a short list: display off, an output-control change, sleep entry and power-register clear.

A fault reported by the writer during any of the three wake-up commands ends the power-up at once and raises a wake fault. A fault on any later write is recorded, and the sequence still runs to its end. The panel-on and backlight outputs rise only once display-on has completed. Both outputs drop as soon as any sequence is accepted, so the backlight is dark before the first power-down write goes out. The pause length comes from the clock frequency and wait-time parameters.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset, busy, panel_on, backlight_en, cmd_start, wake_fail and write_fail are all 0.
- R2: A power-up sends exactly 44 writes. Each write is a one-cycle cmd_start pulse, and the writer's cmd_done completes it. The first three writes are code 0x00 with length 0. Then come 0xB0/0x17, 0xBC/0x80, 0x3B/0x00, 0xB0/0x16, 0xB8/0xFFF9 (length 2) and the no-data 0x11. After those come the 34 tuning writes, and the series closes with the no-data code 0x29.
- R3: Take the cycle in which cmd_done completes one of the three wake-up writes. The next cmd_start comes WAIT_CYC+1 cycles after that cycle. Here WAIT_CYC = (CLK_HZ/1000)*WAIT_US/1000. After every other write that is not the last in its series, the next cmd_start comes 1 cycle after the done cycle.
- R4: If cmd_fail is high with cmd_done on any wake-up write, no further write is issued. In that case busy falls and wake_fail rises in the same cycle, while panel_on and backlight_en stay 0. Accepting the next request clears wake_fail.
- R5: A writer fault on any write after the wake-up stage sets write_fail. The sequence still issues all its writes, and a power-up still ends with panel_on and backlight_en at 1.
- R6: cmd_len holds the payload byte count (0, 1 or 2). For length 2, cmd_data[15:8] is the byte sent first, and cmd_data[7:0] holds the single byte for length 1. Examples: 0xC3 carries 0x2040 and 0xD3 carries 0x0D0E, both with length 2.
- R7: panel_on and backlight_en rise in the same cycle that busy falls after a completed power-up. They are never 1 while busy is 1.
- R8: A power-down sends exactly 4 writes: 0x28 (len 0), 0xB8/0x8002 (len 2), 0x10 (len 0) and 0xB0/0x00 (len 1). panel_on and backlight_en are 0 from the cycle after the request is accepted, and they stay 0 afterwards.
- R9: up_req and down_req have no effect while busy is 1. The running series completes unchanged.
- R10: If up_req and down_req are both high while idle, the power-down series runs.
- R11: busy is 1 from the cycle after a request is sampled in idle until the series ends, and cmd_start is only ever high while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req | input | 1 | Start the power-up series (sampled when idle) |
| down_req | input | 1 | Start the power-down series (sampled when idle, wins over up_req) |
| cmd_start | output | 1 | One-cycle pulse: writer should send the presented write |
| cmd_code | output | 8 | Command code of the presented write |
| cmd_len | output | 2 | Payload byte count, 0 to 2 |
| cmd_data | output | 16 | Payload, high byte first for two-byte writes |
| cmd_done | input | 1 | Writer finished the current write |
| cmd_fail | input | 1 | Writer fault, qualified by cmd_done |
| busy | output | 1 | A series is in progress |
| panel_on | output | 1 | Power-up completed and panel is running |
| backlight_en | output | 1 | Backlight enable |
| wake_fail | output | 1 | Power-up aborted in the wake-up stage |
| write_fail | output | 1 | A later write faulted during the last series |

## Verification
A wrong table index shows up on cmd_code and cmd_data at the very next cmd_start, so every write in the series is compared entry by entry. A delay counter that is loaded wrongly, or a pause on the wrong step, changes the spacing between done and the next start by at least one cycle within the first three writes. A state machine that leaves the wake-up abort path is seen as extra writes after the fault. A stuck busy or an early enable is seen on panel_on and backlight_en in the cycle the series ends.

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq #(
  parameter int CLK_HZ  = 100_000_000,
  parameter int WAIT_US = 1500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        up_req,
  input  logic        down_req,
  output logic        cmd_start,
  output logic [7:0]  cmd_code,
  output logic [1:0]  cmd_len,
  output logic [15:0] cmd_data,
  input  logic        cmd_done,
  input  logic        cmd_fail,
  output logic        busy,
  output logic        panel_on,
  output logic        backlight_en,
  output logic        wake_fail,
  output logic        write_fail
);
  localparam int WAIT_CYC = (CLK_HZ / 1000) * WAIT_US / 1000;
  localparam int CW       = $clog2(WAIT_CYC + 1);
  localparam int IW       = 6;
  localparam int WAKE_N   = 3;
  localparam int UP_FIRST = 0;
  localparam int UP_LAST  = 43;
  localparam int DN_FIRST = 44;
  localparam int DN_LAST  = 47;

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT_WR, S_DELAY, S_DONE, S_ERROR} st_t;

  st_t           state;
  logic [IW-1:0] idx;
  logic [CW-1:0] cnt;
  logic          going_up;
  logic [26:0]   ent;

  function automatic logic [26:0] rom(input logic [IW-1:0] i);
    case (i)
      6'd0:  return {8'h00, 2'd0, 16'h0000, 1'b1};
      6'd1:  return {8'h00, 2'd0, 16'h0000, 1'b1};
      6'd2:  return {8'h00, 2'd0, 16'h0000, 1'b1};
      6'd3:  return {8'hB0, 2'd1, 16'h0017, 1'b0};
      6'd4:  return {8'hBC, 2'd1, 16'h0080, 1'b0};
      6'd5:  return {8'h3B, 2'd1, 16'h0000, 1'b0};
      6'd6:  return {8'hB0, 2'd1, 16'h0016, 1'b0};
      6'd7:  return {8'hB8, 2'd2, 16'hFFF9, 1'b0};
      6'd8:  return {8'h11, 2'd0, 16'h0000, 1'b0};
      6'd9:  return {8'hBA, 2'd1, 16'h0001, 1'b0};
      6'd10: return {8'hBB, 2'd1, 16'h0000, 1'b0};
      6'd11: return {8'h3A, 2'd1, 16'h0060, 1'b0};
      6'd12: return {8'hBF, 2'd1, 16'h0010, 1'b0};
      6'd13: return {8'hB1, 2'd1, 16'h0056, 1'b0};
      6'd14: return {8'hB2, 2'd1, 16'h0033, 1'b0};
      6'd15: return {8'hB3, 2'd1, 16'h0011, 1'b0};
      6'd16: return {8'hB3, 2'd1, 16'h0011, 1'b0};
      6'd17: return {8'hB4, 2'd1, 16'h0002, 1'b0};
      6'd18: return {8'hB5, 2'd1, 16'h002B, 1'b0};
      6'd19: return {8'hB6, 2'd1, 16'h0040, 1'b0};
      6'd20: return {8'hB7, 2'd1, 16'h0003, 1'b0};
      6'd21: return {8'hB9, 2'd1, 16'h0004, 1'b0};
      6'd22: return {8'hBD, 2'd1, 16'h0004, 1'b0};
      6'd23: return {8'hBE, 2'd1, 16'h0000, 1'b0};
      6'd24: return {8'hC0, 2'd1, 16'h0011, 1'b0};
      6'd25: return {8'hC1, 2'd1, 16'h0011, 1'b0};
      6'd26: return {8'hC2, 2'd1, 16'h0011, 1'b0};
      6'd27: return {8'hC3, 2'd2, 16'h2040, 1'b0};
      6'd28: return {8'hC4, 2'd2, 16'h60C0, 1'b0};
      6'd29: return {8'hC5, 2'd2, 16'h1020, 1'b0};
      6'd30: return {8'hC6, 2'd2, 16'h60C0, 1'b0};
      6'd31: return {8'hC7, 2'd2, 16'h5533, 1'b0};
      6'd32: return {8'hC8, 2'd1, 16'h0000, 1'b0};
      6'd33: return {8'hC9, 2'd1, 16'h0000, 1'b0};
      6'd34: return {8'hCA, 2'd1, 16'h0000, 1'b0};
      6'd35: return {8'hEC, 2'd2, 16'h01F0, 1'b0};
      6'd36: return {8'hCF, 2'd1, 16'h0002, 1'b0};
      6'd37: return {8'hD0, 2'd2, 16'h0804, 1'b0};
      6'd38: return {8'hD1, 2'd1, 16'h0001, 1'b0};
      6'd39: return {8'hD2, 2'd2, 16'h0000, 1'b0};
      6'd40: return {8'hD3, 2'd2, 16'h0D0E, 1'b0};
      6'd41: return {8'hD4, 2'd2, 16'h11A4, 1'b0};
      6'd42: return {8'hD5, 2'd1, 16'h000E, 1'b0};
      6'd43: return {8'h29, 2'd0, 16'h0000, 1'b0};
      6'd44: return {8'h28, 2'd0, 16'h0000, 1'b0};
      6'd45: return {8'hB8, 2'd2, 16'h8002, 1'b0};
      6'd46: return {8'h10, 2'd0, 16'h0000, 1'b0};
      6'd47: return {8'hB0, 2'd1, 16'h0000, 1'b0};
      default: return 27'd0;
    endcase
  endfunction

  assign ent       = rom(idx);
  assign cmd_code  = ent[26:19];
  assign cmd_len   = ent[18:17];
  assign cmd_data  = ent[16:1];
  assign cmd_start = (state == S_ISSUE);
  assign busy      = (state != S_IDLE);

  wire in_wake = going_up && (idx < IW'(WAKE_N));
  wire at_last = going_up ? (idx == IW'(UP_LAST)) : (idx == IW'(DN_LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      idx          <= '0;
      cnt          <= '0;
      going_up     <= 1'b0;
      panel_on     <= 1'b0;
      backlight_en <= 1'b0;
      wake_fail    <= 1'b0;
      write_fail   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (down_req || up_req) begin
            idx          <= down_req ? IW'(DN_FIRST) : IW'(UP_FIRST);
            going_up     <= !down_req;
            panel_on     <= 1'b0;
            backlight_en <= 1'b0;
            wake_fail    <= 1'b0;
            write_fail   <= 1'b0;
            state        <= S_ISSUE;
          end
        end
        S_ISSUE: state <= S_WAIT_WR;
        S_WAIT_WR: begin
          if (cmd_done) begin
            if (cmd_fail && in_wake) begin
              state <= S_ERROR;
            end else begin
              if (cmd_fail) write_fail <= 1'b1;
              if (ent[0]) begin
                cnt   <= CW'(WAIT_CYC - 1);
                state <= S_DELAY;
              end else if (at_last) begin
                state <= S_DONE;
              end else begin
                idx   <= idx + 1'b1;
                state <= S_ISSUE;
              end
            end
          end
        end
        S_DELAY: begin
          if (cnt == '0) begin
            idx   <= idx + 1'b1;
            state <= S_ISSUE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_DONE: begin
          panel_on     <= going_up;
          backlight_en <= going_up;
          state        <= S_IDLE;
        end
        S_ERROR: begin
          wake_fail <= 1'b1;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module panel_pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_start,
  input logic [7:0] cmd_code,
  input logic [1:0] cmd_len,
  input logic       busy,
  input logic       panel_on,
  input logic       backlight_en,
  input logic       wake_fail
);
  AST_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> busy); // R11
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start); // R2
  AST_NULL_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_code == 8'h00) |-> (cmd_len == 2'd0)); // R2
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> (cmd_len != 2'd3)); // R6
  AST_ON_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(panel_on) |-> $fell(busy)); // R7
  AST_OFF_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!panel_on && !backlight_en)); // R7
  AST_WAKE_FAIL_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    wake_fail |-> (!panel_on && !backlight_en)); // R4
endmodule

bind panel_pwr_seq panel_pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_code(cmd_code),
  .cmd_len(cmd_len), .busy(busy), .panel_on(panel_on),
  .backlight_en(backlight_en), .wake_fail(wake_fail)
);

// File: tb/panel_pwr_seq_tb.sv
module panel_pwr_seq_tb;
  localparam int WAITC = 20;
  localparam int UP_N  = 44;
  localparam int DN_N  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_req = 1'b0, down_req = 1'b0;
  logic cmd_done = 1'b0, cmd_fail = 1'b0;
  logic cmd_start, busy, panel_on, backlight_en, wake_fail, write_fail;
  logic [7:0]  cmd_code;
  logic [1:0]  cmd_len;
  logic [15:0] cmd_data;

  always #5 clk = ~clk;

  panel_pwr_seq #(.CLK_HZ(1_000_000), .WAIT_US(20)) u_dut (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .down_req(down_req),
    .cmd_start(cmd_start), .cmd_code(cmd_code), .cmd_len(cmd_len),
    .cmd_data(cmd_data), .cmd_done(cmd_done), .cmd_fail(cmd_fail),
    .busy(busy), .panel_on(panel_on), .backlight_en(backlight_en),
    .wake_fail(wake_fail), .write_fail(write_fail)
  );

  int total = 0, bad = 0;
  int cyc = 0;
  int n = 0;
  int wcnt = 0;
  int overlap = 0;
  logic [63:0] fail_mask = '0;
  logic [25:0] lg[64];
  int st_cyc[64];
  int dn_cyc[64];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [25:0] exp_cmd(input int k);
    case (k)
      0, 1, 2: return {8'h00, 2'd0, 16'h0000};
      3:  return {8'hB0, 2'd1, 16'h0017};
      4:  return {8'hBC, 2'd1, 16'h0080};
      5:  return {8'h3B, 2'd1, 16'h0000};
      6:  return {8'hB0, 2'd1, 16'h0016};
      7:  return {8'hB8, 2'd2, 16'hFFF9};
      8:  return {8'h11, 2'd0, 16'h0000};
      9:  return {8'hBA, 2'd1, 16'h0001};
      10: return {8'hBB, 2'd1, 16'h0000};
      11: return {8'h3A, 2'd1, 16'h0060};
      12: return {8'hBF, 2'd1, 16'h0010};
      13: return {8'hB1, 2'd1, 16'h0056};
      14: return {8'hB2, 2'd1, 16'h0033};
      15, 16: return {8'hB3, 2'd1, 16'h0011};
      17: return {8'hB4, 2'd1, 16'h0002};
      18: return {8'hB5, 2'd1, 16'h002B};
      19: return {8'hB6, 2'd1, 16'h0040};
      20: return {8'hB7, 2'd1, 16'h0003};
      21: return {8'hB9, 2'd1, 16'h0004};
      22: return {8'hBD, 2'd1, 16'h0004};
      23: return {8'hBE, 2'd1, 16'h0000};
      24: return {8'hC0, 2'd1, 16'h0011};
      25: return {8'hC1, 2'd1, 16'h0011};
      26: return {8'hC2, 2'd1, 16'h0011};
      27: return {8'hC3, 2'd2, 16'h2040};
      28: return {8'hC4, 2'd2, 16'h60C0};
      29: return {8'hC5, 2'd2, 16'h1020};
      30: return {8'hC6, 2'd2, 16'h60C0};
      31: return {8'hC7, 2'd2, 16'h5533};
      32: return {8'hC8, 2'd1, 16'h0000};
      33: return {8'hC9, 2'd1, 16'h0000};
      34: return {8'hCA, 2'd1, 16'h0000};
      35: return {8'hEC, 2'd2, 16'h01F0};
      36: return {8'hCF, 2'd1, 16'h0002};
      37: return {8'hD0, 2'd2, 16'h0804};
      38: return {8'hD1, 2'd1, 16'h0001};
      39: return {8'hD2, 2'd2, 16'h0000};
      40: return {8'hD3, 2'd2, 16'h0D0E};
      41: return {8'hD4, 2'd2, 16'h11A4};
      42: return {8'hD5, 2'd1, 16'h000E};
      43: return {8'h29, 2'd0, 16'h0000};
      44: return {8'h28, 2'd0, 16'h0000};
      45: return {8'hB8, 2'd2, 16'h8002};
      46: return {8'h10, 2'd0, 16'h0000};
      47: return {8'hB0, 2'd1, 16'h0000};
      default: return 26'd0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // writer model and monitor, all at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      cmd_done = 1'b0;
      cmd_fail = 1'b0;
      if (busy && (panel_on || backlight_en)) overlap++;
      if (wcnt > 0) begin
        wcnt--;
        if (wcnt == 0) begin
          cmd_done = 1'b1;
          cmd_fail = fail_mask[n-1];
          dn_cyc[n-1] = cyc;
        end
      end
      if (cmd_start && n < 64) begin
        lg[n] = {cmd_code, cmd_len, cmd_data};
        st_cyc[n] = cyc;
        n++;
        wcnt = 1 + int'($urandom_range(0, 3));
      end
    end
  end

  task automatic pulse(input bit u, input bit d);
    @(negedge clk);
    up_req = u;
    down_req = d;
    @(negedge clk);
    up_req = 1'b0;
    down_req = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run(input bit u, input bit d, input logic [63:0] mask);
    n = 0;
    fail_mask = mask;
    pulse(u, d);
    check(busy === 1'b1, "R11 busy after accept", busy, 1);
    check(panel_on === 1'b0 && backlight_en === 1'b0, "R8 dark after accept",
          {panel_on, backlight_en}, 0);
    wait_idle();
  endtask

  task automatic check_log(input int first, input int cnt, input string tag);
    check(n == cnt, {tag, " write count"}, n, cnt);
    for (int k = 0; k < cnt && k < n; k++)
      check(lg[k] == exp_cmd(first + k), {tag, " write content"}, lg[k], exp_cmd(first + k));
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check({busy, panel_on, backlight_en, cmd_start, wake_fail, write_fail} == 6'b0,
          "R1 reset state", {busy, panel_on, backlight_en, cmd_start, wake_fail, write_fail}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R6 R7: clean power-up
    run(1'b1, 1'b0, '0);
    check_log(0, UP_N, "R2");
    for (int k = 0; k < 3; k++)
      check(st_cyc[k+1] - dn_cyc[k] == WAITC + 1, "R3 wake gap", st_cyc[k+1] - dn_cyc[k], WAITC + 1);
    for (int k = 3; k < UP_N - 1; k++)
      check(st_cyc[k+1] - dn_cyc[k] == 1, "R3 plain gap", st_cyc[k+1] - dn_cyc[k], 1);
    check(lg[27] == {8'hC3, 2'd2, 16'h2040} && lg[40] == {8'hD3, 2'd2, 16'h0D0E},
          "R6 two-byte writes", lg[27], {8'hC3, 2'd2, 16'h2040});
    check(panel_on && backlight_en && !write_fail, "R7 on after power-up",
          {panel_on, backlight_en, write_fail}, 3'b110);

    // R8 power-down
    run(1'b0, 1'b1, '0);
    check_log(44, DN_N, "R8");
    check(!panel_on && !backlight_en, "R8 dark after power-down", {panel_on, backlight_en}, 0);

    // R9 requests ignored while busy
    n = 0;
    fail_mask = '0;
    pulse(1'b1, 1'b0);
    repeat (40) @(negedge clk);
    pulse(1'b0, 1'b1);
    repeat (5) @(negedge clk);
    pulse(1'b1, 1'b1);
    wait_idle();
    check_log(0, UP_N, "R9");
    check(panel_on === 1'b1, "R9 up series unaffected", panel_on, 1);

    // R10 both requests from idle
    run(1'b1, 1'b1, '0);
    check_log(44, DN_N, "R10");
    check(panel_on === 1'b0, "R10 down wins", panel_on, 0);

    // R4 wake-up fault
    begin
      int w;
      w = int'($urandom_range(0, 2));
      run(1'b1, 1'b0, 64'd1 << w);
      check(n == w + 1, "R4 stop after wake fault", n, w + 1);
      check(wake_fail && !panel_on && !backlight_en && !busy, "R4 fault state",
            {wake_fail, panel_on, backlight_en, busy}, 4'b1000);
      n = 0;
      fail_mask = '0;
      pulse(1'b1, 1'b0);
      check(wake_fail === 1'b0, "R4 cleared on accept", wake_fail, 0);
      wait_idle();
      check(panel_on === 1'b1, "R4 recovery", panel_on, 1);
    end

    // R5 late faults, random
    for (int it = 0; it < 6; it++) begin
      logic [63:0] m;
      m = '0;
      for (int j = 0; j < 3; j++) m[3 + $urandom_range(0, UP_N - 4)] = 1'b1;
      run(1'b1, 1'b0, m);
      check_log(0, UP_N, "R5");
      check(write_fail && panel_on && backlight_en && !wake_fail, "R5 complete despite faults",
            {write_fail, panel_on, backlight_en, wake_fail}, 4'b1110);
    end

    // mixed random series
    for (int it = 0; it < 10; it++) begin
      bit d;
      d = 1'($urandom_range(0, 1));
      run(!d, d, '0);
      check(n == (d ? DN_N : UP_N), "R2 R8 random count", n, d ? DN_N : UP_N);
      check(panel_on == !d && backlight_en == !d, "R7 R8 random end state",
            {panel_on, backlight_en}, d ? 0 : 3);
    end

    check(overlap == 0, "R7 never on while busy", overlap, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule